// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between the serial bus engine of a small byte-addressed nonvolatile store and its memory array. Once the engine has received the word address of a write transaction, the block latches that address. It then gathers each acknowledged data byte into an eight-entry page buffer. When the transaction closes, the buffered bytes are committed to the array. Only the low three address bits advance from byte to byte. Past the end of the page the index wraps to the first entry of the same page, so a long burst overwrites the bytes it sent earlier.

A stop event that follows at least one complete data byte starts the timed commit. The busy flag rises and the array write port replays the valid entries, one per clock and in index order. The busy flag then stays high until a parameterised count of system clocks has elapsed. While busy, every bus input is ignored. When the window ends, the block pulses `done` and presents the post-write word address, so the engine can update its own address counter. With the protect input high, the window still runs but nothing reaches the array. A repeated start, or a stop with no complete byte, ends the transaction with no commit.

Top module: `pgwr_commit`

## Requirements
- R1: The loaded address splits into a page field (upper ADDR_W-IDX_W bits, 5 bits by default) and an index field (low IDX_W bits, 3 by default). Each accepted byte increments only the index. The index wraps from 7 to 0, and the page field never changes inside a transaction.
- R2: When more than eight bytes arrive in one transaction, a later byte at the same index replaces the earlier one. The array receives only the last value for each index.
- R3: Only the indices that received a byte are written. The other addresses of the page see no write.
- R4: A stop accepted while no complete byte is buffered ends the transaction. Busy stays low and nothing is written.
- R5: A repeated start (`bus_start`) during a transaction discards the buffered bytes. A later stop then produces no busy window and no write.
- R6: After a committing stop is sampled at a clock edge, `busy` is high from that edge on, for exactly BUSY_CYCLES clock cycles.
- R7: Array writes happen only while busy, within the first 2**IDX_W busy cycles. Busy cycle k, counted from 0, serves index k, at address {page, k}.
- R8: While `wp_in` is high, `mem_we` stays low. The busy window still runs for its full length.
- R9: While busy, `addr_load`, `byte_valid`, `bus_start` and `bus_stop` have no effect. They start no window, cause no write and leave `final_addr` unchanged.
- R10: In the first cycle after busy falls, `done` is high for one cycle. `final_addr` then equals {page, (start index + byte count) mod 8}.
- R11: After reset, `busy`, `mem_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Pulse: latch `load_addr` and open a write transaction |
| load_addr | input | ADDR_W | Starting word address |
| byte_valid | input | 1 | Pulse: one complete, acknowledged data byte |
| byte_data | input | DATA_W | Data byte qualified by `byte_valid` |
| bus_start | input | 1 | Pulse: repeated start seen on the bus |
| bus_stop | input | 1 | Pulse: stop seen on the bus |
| wp_in | input | 1 | High blocks every array write |
| busy | output | 1 | Timed write window in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| done | output | 1 | One-cycle pulse after the busy window |
| final_addr | output | ADDR_W | Word address after the transaction |

## Verification
Inputs are driven just after a rising edge. The stop is therefore sampled at the next edge E, and `busy` must read high immediately after E. The bench counts busy cycles at each falling edge and expects exactly BUSY_CYCLES of them. Each write is tagged with its busy-cycle index, so the first and last write slots can be compared with the indices that were loaded. `done` and `final_addr` are read one edge after the first low-busy falling edge. The ignore and no-commit cases are confirmed by watching busy, writes and `done` for several further cycles.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_t;
endpackage

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0]  hit;
   logic [DEPTH-1:0]  valid_q;
   logic [DATA_W-1:0] data_q [DEPTH];

   // one decoded write select per entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_hit
      assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (clr)         valid_q[i] <= 1'b0;
            else if (hit[i]) valid_q[i] <= 1'b1;
            if (hit[i])      data_q[i]  <= wr_data;   // later byte replaces earlier one
         end
      end
   end

   assign rd_data   = data_q[rd_idx];
   assign rd_valid  = valid_q[rd_idx];
   assign any_valid = |valid_q;

   // R3: a cleared buffer holds no valid entry in the following cycle
   p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !any_valid);
endmodule

// File: rtl/pgwr_busy_timer.sv
module pgwr_busy_timer #(
   parameter int CYCLES = 500000,
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   assign last = run && (cnt == CNT_W'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (!run) begin
         if (kick) begin
            run <= 1'b1;
            cnt <= '0;
         end
      end else if (last) begin
         run <= 1'b0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R6: the window cannot close before its final count
   p_window_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !last) |=> run);
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
   import pgwr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int IDX_W       = 3,
   parameter int DATA_W      = 8,
   parameter int BUSY_CYCLES = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              wp_in,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              done,
   output logic [ADDR_W-1:0] final_addr
);
   localparam int DEPTH  = 1 << IDX_W;
   localparam int PAGE_W = ADDR_W - IDX_W;
   localparam int CNT_W  = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

   initial begin
      assert (ADDR_W > IDX_W && IDX_W >= 1)
         else $error("pgwr_commit: ADDR_W must exceed IDX_W");
      assert (BUSY_CYCLES >= DEPTH)
         else $error("pgwr_commit: busy window shorter than page drain");
   end

   fill_state_t       state_q;
   logic [PAGE_W-1:0] page_q;
   logic [IDX_W-1:0]  idx_q;
   logic              done_q;

   logic              run, last, kick, buf_clr, buf_wr;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid, any_valid;
   logic [IDX_W-1:0]  drain_idx;
   logic              drain_win;

   // inputs count only while the timed window is idle
   assign buf_clr = !run && (state_q == FS_IDLE) && addr_load;
   assign buf_wr  = !run && (state_q == FS_FILL) && !bus_start && !bus_stop && byte_valid;
   assign kick    = !run && (state_q == FS_FILL) && !bus_start && bus_stop && any_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         page_q  <= '0;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (!run) begin
            case (state_q)
               FS_IDLE: if (addr_load) begin
                  page_q  <= load_addr[ADDR_W-1:IDX_W];
                  idx_q   <= load_addr[IDX_W-1:0];
                  state_q <= FS_FILL;
               end
               FS_FILL: begin
                  if (bus_start || bus_stop) state_q <= FS_IDLE;
                  else if (byte_valid)       idx_q   <= idx_q + IDX_W'(1);
               end
               default: state_q <= FS_IDLE;
            endcase
         end
      end
   end

   pgwr_page_buf #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (buf_clr),
      .wr_en     (buf_wr),
      .wr_idx    (idx_q),
      .wr_data   (byte_data),
      .rd_idx    (drain_idx),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .any_valid (any_valid)
   );

   pgwr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (kick),
      .run   (run),
      .cnt   (cnt),
      .last  (last)
   );

   // the first DEPTH cycles of the window replay the buffer in index order
   assign drain_idx  = cnt[IDX_W-1:0];
   assign drain_win  = run && (32'(cnt) < DEPTH);
   assign mem_we     = drain_win && rd_valid && !wp_in;
   assign mem_addr   = {page_q, drain_idx};
   assign mem_wdata  = rd_data;
   assign busy       = run;
   assign done       = done_q;
   assign final_addr = {page_q, idx_q};

   p_write_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   p_protect_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wp_in |-> !mem_we);
   p_page_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_FILL) |=> (page_q == $past(page_q)));
   p_done_after_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   p_busy_freezes_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (final_addr == $past(final_addr)));
endmodule

// File: tb/pgwr_commit_bench.sv
module pgwr_commit_bench;
   localparam int BUSY = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0, byte_valid = 1'b0, bus_start = 1'b0, bus_stop = 1'b0, wp_in = 1'b0;
   logic [7:0] load_addr = '0, byte_data = '0;
   logic       busy, mem_we, done;
   logic [7:0] mem_addr, mem_wdata, final_addr;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   logic [7:0] sh [256];
   bit         wf [256];
   int bcnt, wr_cnt, first_slot, last_slot, done_cnt;
   logic [7:0] done_addr;

   pgwr_commit #(.BUSY_CYCLES(BUSY)) u_pgwr_commit (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
      .byte_valid(byte_valid), .byte_data(byte_data), .bus_start(bus_start),
      .bus_stop(bus_stop), .wp_in(wp_in), .busy(busy), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .final_addr(final_addr));

   always #5 clk = ~clk;

   // observer at the falling edge
   always @(negedge clk) begin
      if (rst_n && busy) begin
         if (mem_we) begin
            sh[mem_addr] = mem_wdata;
            wf[mem_addr] = 1'b1;
            wr_cnt++;
            if (first_slot < 0) first_slot = bcnt;
            last_slot = bcnt;
         end
         bcnt++;
      end
      if (rst_n && done) begin
         done_cnt++;
         done_addr = final_addr;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic clear_obs();
      for (int i = 0; i < 256; i++) begin sh[i] = '0; wf[i] = 1'b0; end
      bcnt = 0; wr_cnt = 0; first_slot = -1; last_slot = -1; done_cnt = 0; done_addr = '0;
   endtask

   task automatic load(input logic [7:0] a);
      addr_load = 1'b1; load_addr = a; step(); addr_load = 1'b0;
   endtask

   task automatic send(input logic [7:0] d);
      byte_valid = 1'b1; byte_data = d; step(); byte_valid = 1'b0;
   endtask

   task automatic stop();
      bus_stop = 1'b1; step(); bus_stop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
      step();
   endtask

   task automatic t_reset();
      chk("R11 busy", int'(busy), 0);
      chk("R11 mem_we", int'(mem_we), 0);
      chk("R11 done", int'(done), 0);
   endtask

   task automatic t_single();
      clear_obs();
      load(8'h25); send(8'hA1); stop();
      chk("R6 busy after stop", int'(busy), 1);
      wait_idle();
      chk("R6 window length", bcnt, BUSY);
      chk("R7 write count", wr_cnt, 1);
      chk("R7 write slot", first_slot, 5);
      chk("R3 data", int'(sh[8'h25]), 'hA1);
      chk("R10 done pulses", done_cnt, 1);
      chk("R10 final addr", int'(done_addr), 'h26);
   endtask

   task automatic t_wrap();
      clear_obs();
      load(8'h3E);
      for (int i = 0; i < 10; i++) send(8'(8'h10 + i));
      stop(); wait_idle();
      chk("R2 write count", wr_cnt, 8);
      chk("R2 idx6 overwritten", int'(sh[8'h3E]), 'h18);
      chk("R2 idx7 overwritten", int'(sh[8'h3F]), 'h19);
      chk("R1 idx0 in page", int'(sh[8'h38]), 'h12);
      chk("R1 next page untouched", int'(wf[8'h40]), 0);
      chk("R7 first slot", first_slot, 0);
      chk("R7 last slot", last_slot, 7);
      chk("R10 wrapped final addr", int'(done_addr), 'h38);
   endtask

   task automatic t_partial();
      clear_obs();
      load(8'h80); send(8'h5A); send(8'h5B); send(8'h5C);
      stop(); wait_idle();
      chk("R3 write count", wr_cnt, 3);
      chk("R3 idx2 data", int'(sh[8'h82]), 'h5C);
      chk("R3 idx3 untouched", int'(wf[8'h83]), 0);
      chk("R7 last slot", last_slot, 2);
      chk("R10 final addr", int'(done_addr), 'h83);
   endtask

   task automatic t_nobyte();
      clear_obs();
      load(8'h11); stop();
      for (int i = 0; i < 4; i++) begin
         chk("R4 no busy", int'(busy), 0);
         step();
      end
      chk("R4 no writes", wr_cnt, 0);
      chk("R4 no done", done_cnt, 0);
   endtask

   task automatic t_restart();
      clear_obs();
      load(8'h40); send(8'h77); send(8'h78);
      bus_start = 1'b1; step(); bus_start = 1'b0;
      stop();
      for (int i = 0; i < 4; i++) begin
         chk("R5 no busy", int'(busy), 0);
         step();
      end
      chk("R5 no writes", wr_cnt, 0);
   endtask

   task automatic t_protect();
      clear_obs();
      wp_in = 1'b1;
      load(8'hF7); send(8'h99); stop();
      chk("R8 busy still runs", int'(busy), 1);
      wait_idle();
      wp_in = 1'b0;
      chk("R8 window length", bcnt, BUSY);
      chk("R8 no writes", wr_cnt, 0);
      chk("R10 final addr wraps", int'(done_addr), 'hF0);
   endtask

   task automatic t_ignore();
      clear_obs();
      load(8'h5A); send(8'h33); stop();
      step(); step();
      load(8'h10); send(8'hEE); stop();
      bus_start = 1'b1; step(); bus_start = 1'b0;
      wait_idle();
      chk("R9 window not extended", bcnt, BUSY);
      chk("R9 one write", wr_cnt, 1);
      chk("R9 stray addr untouched", int'(wf[8'h10]), 0);
      chk("R9 final addr kept", int'(done_addr), 'h5B);
      for (int i = 0; i < 5; i++) step();
      chk("R9 no new window", int'(busy), 0);
      chk("R9 single done", done_cnt, 1);
   endtask

   initial begin
      clear_obs();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      step();
      t_reset();
      t_single();
      t_wrap();
      t_partial();
      t_nobyte();
      t_restart();
      t_protect();
      t_ignore();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule